// File: doc/BRIEF.md
# Two-Level Shared Interrupt Controller

This block gathers the event lines of a flash-card host controller into a local status register, with a matching local enable register. The enabled local status feeds one bit of a global status register. A second bit of that global register belongs to a sibling peripheral controller, whose request arrives as a pulse. Each global bit has two enables. A status-enable decides whether the bit may latch. A signal-enable decides whether the latched bit may drive the single registered interrupt line.

Software reaches every register through a single-cycle write strobe and a combinational read port. Both status registers clear on a write of one. In each bit, a new set takes priority over a clear that lands in the same cycle.

Top module: `cf_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: A local event sets its local status bit (address 0) in the next cycle even when that bit is disabled. An event and a write-one-to-clear of the same bit in the same cycle leave the bit set.
- R3: Writing address 0 clears exactly the local status bits written as one. Other bits keep their value.
- R4: Local status and enable implement only bits 0-3 and 8-11 (card detect, status change, memory mode, I/O mode, true-IDE mode, PIO error, buffer available, transfer done). Other bit positions read zero. Events on those positions are ignored. The enable register (address 1) is read/write.
- R5: Global status bit 0 (address 2) is set one cycle after any enabled local status bit is high, but only while status-enable bit 0 (address 3) is set. It stays set until cleared. A clear while the request is still active leaves it set.
- R6: A pulse on sib_req_i sets global status bit 1 in the next cycle, but only while status-enable bit 1 is set.
- R7: irq_o is the OR over the global bits of status AND signal-enable (address 4), registered. It changes one cycle after the global status or signal-enable changes.
- R8: Writing address 2 clears exactly the global bits written as one. A write to an unmapped address changes no register.
- R9: Clearing a status-enable bit leaves an already latched global bit set. It only stops new sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, one cycle |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| src_evt_i | input | LOC_W | Local event lines, one per local status bit |
| sib_req_i | input | 1 | Sibling peripheral request pulse |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that the event, request and write inputs are stable around the sampling edge. They also assume that a write strobe lasts exactly one cycle and carries a settled address. The bench drives every input on the falling edge and holds it through one rising edge, so each strobe or pulse covers exactly one sampling point. Reads are taken after a short settle delay between edges. Simultaneous set and clear is produced on purpose, by raising an event in the same half-cycle as a clearing write.

// File: rtl/cf_irq_pkg.sv
package cf_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned GLB_W  = 2;
  localparam int unsigned GBIT_CARD = 0;
  localparam int unsigned GBIT_SIB  = 1;

  localparam logic [ADDR_W-1:0] ADR_LSTAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LEN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_GSTAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_GSEN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_GSIG  = 3'd4;
endpackage

// File: rtl/irq_local_bank.sv
module irq_local_bank #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] MASK = 12'hF0F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] en_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, en_q;
  logic unused_bits;
  assign unused_bits = ^((evt_i | clr_i | en_wdata_i) & ~MASK);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MASK[b]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stat_q[b] <= 1'b0;
          en_q[b]   <= 1'b0;
        end else begin
          stat_q[b] <= (stat_q[b] & ~clr_i[b]) | evt_i[b];  // set wins
          if (en_we_i) en_q[b] <= en_wdata_i[b];
        end
      end

      p_set_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[b] |=> stat_q[b]);
      p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[b] && !evt_i[b]) |=> !stat_q[b]);
      p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_q[b] && !clr_i[b]) |=> stat_q[b]);
    end else begin : g_none
      assign stat_q[b] = 1'b0;
      assign en_q[b]   = 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign pend_o = |(stat_q & en_q);
endmodule

// File: rtl/irq_global_bank.sv
module irq_global_bank
  import cf_irq_pkg::*;
#(
  parameter int unsigned GW = GLB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] req_i,
  input  logic [GW-1:0] clr_i,
  input  logic          sen_we_i,
  input  logic          sig_we_i,
  input  logic [GW-1:0] wdata_i,
  output logic [GW-1:0] stat_o,
  output logic [GW-1:0] sen_o,
  output logic [GW-1:0] sig_o,
  output logic          irq_o
);
  logic [GW-1:0] stat_q, sen_q, sig_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      sen_q  <= '0;
      sig_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_i) | (req_i & sen_q);
      if (sen_we_i) sen_q <= wdata_i;
      if (sig_we_i) sig_q <= wdata_i;
      irq_q <= |(stat_q & sig_q);
    end
  end

  assign stat_o = stat_q;
  assign sen_o  = sen_q;
  assign sig_o  = sig_q;
  assign irq_o  = irq_q;

  for (genvar g = 0; g < GW; g++) begin : g_chk
    p_latch_r5_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[g] && sen_q[g]) |=> stat_q[g]);
    p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sen_q[g] && !stat_q[g]) |=> !stat_q[g]);
    p_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[g] && !clr_i[g]) |=> stat_q[g]);
  end

  p_irq_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_q & sig_q)) |=> irq_q);
  p_irq_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(stat_q & sig_q)) |=> !irq_q);
endmodule

// File: rtl/cf_irq_ctrl.sv
module cf_irq_ctrl
  import cf_irq_pkg::*;
#(
  parameter int unsigned      DATA_W   = 32,
  parameter int unsigned      LOC_W    = 12,
  parameter logic [LOC_W-1:0] LOC_MASK = 12'hF0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [LOC_W-1:0]  src_evt_i,
  input  logic              sib_req_i,
  output logic              irq_o
);
  logic [LOC_W-1:0] lstat, len, lclr;
  logic             lpend;
  logic [GLB_W-1:0] gstat, gsen, gsig, gclr, greq;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:LOC_W];

  assign lclr = (reg_we_i && reg_addr_i == ADR_LSTAT) ? reg_wdata_i[LOC_W-1:0] : '0;
  assign gclr = (reg_we_i && reg_addr_i == ADR_GSTAT) ? reg_wdata_i[GLB_W-1:0] : '0;

  irq_local_bank #(.W(LOC_W), .MASK(LOC_MASK)) u_local (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (src_evt_i),
    .clr_i      (lclr),
    .en_we_i    (reg_we_i && reg_addr_i == ADR_LEN),
    .en_wdata_i (reg_wdata_i[LOC_W-1:0]),
    .stat_o     (lstat),
    .en_o       (len),
    .pend_o     (lpend)
  );

  always_comb begin
    greq = '0;
    greq[GBIT_CARD] = lpend;
    greq[GBIT_SIB]  = sib_req_i;
  end

  irq_global_bank #(.GW(GLB_W)) u_global (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (greq),
    .clr_i    (gclr),
    .sen_we_i (reg_we_i && reg_addr_i == ADR_GSEN),
    .sig_we_i (reg_we_i && reg_addr_i == ADR_GSIG),
    .wdata_i  (reg_wdata_i[GLB_W-1:0]),
    .stat_o   (gstat),
    .sen_o    (gsen),
    .sig_o    (gsig),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADR_LSTAT: reg_rdata_o[LOC_W-1:0] = lstat;
      ADR_LEN:   reg_rdata_o[LOC_W-1:0] = len;
      ADR_GSTAT: reg_rdata_o[GLB_W-1:0] = gstat;
      ADR_GSEN:  reg_rdata_o[GLB_W-1:0] = gsen;
      ADR_GSIG:  reg_rdata_o[GLB_W-1:0] = gsig;
      default:   reg_rdata_o = '0;
    endcase
  end

  p_card_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lstat & len) && gsen[GBIT_CARD]) |=> gstat[GBIT_CARD]);
endmodule

// File: tb/tb_cf_irq_ctrl.sv
module tb_cf_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [LW-1:0] evt = '0;
  logic          sib = 1'b0;
  logic          irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cf_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_evt_i(evt),
    .sib_req_i(sib), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_evt(input logic [LW-1:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic pulse_sib();
    @(negedge clk); sib = 1'b1;
    @(negedge clk); sib = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 5; a++) rchk("R1 reg", 3'(a), 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enable_layout();
    wr(1, 32'hFFFF_FFFF);
    rchk("R4 enable layout", 1, 32'hF0F);
    wr(1, 32'h0);
    rchk("R4 enable cleared", 1, 0);
  endtask

  task automatic t_event_disabled();
    wr(3, 3); wr(4, 3);
    pulse_evt(12'h200);
    rchk("R2 disabled bit sets", 0, 32'h200);
    idle(3);
    rchk("R5 no global without enable", 2, 0);
    chk("R5 irq low", {31'b0, irq}, 0);
    wr(0, 32'h200);
    rchk("R3 clear", 0, 0);
  endtask

  task automatic t_unimpl();
    pulse_evt(12'h0F0);
    rchk("R4 unimplemented events ignored", 0, 0);
  endtask

  task automatic t_w1c();
    pulse_evt(12'hF0F);
    rchk("R2 all implemented set", 0, 32'hF0F);
    wr(0, 32'h00A);
    rchk("R3 exact clear", 0, 32'hF05);
    wr(0, 32'hF05);
    rchk("R3 clear rest", 0, 0);
  endtask

  task automatic t_set_wins();
    pulse_evt(12'h009);
    @(negedge clk); we = 1'b1; addr = 0; wdata = 32'h009; evt = 12'h008;
    @(negedge clk); we = 1'b0; wdata = '0; evt = '0;
    rchk("R2 set wins over clear", 0, 32'h008);
    wr(0, 32'h008);
  endtask

  task automatic t_global_card();
    wr(1, 32'h800); wr(3, 1); wr(4, 1);
    pulse_evt(12'h800);
    rchk("R5 global not yet", 2, 0);
    idle(1);
    rchk("R5 global set", 2, 1);
    chk("R7 irq registered", {31'b0, irq}, 0);
    idle(1);
    chk("R7 irq high", {31'b0, irq}, 1);
    wr(2, 1);
    rchk("R5 clear while pending keeps bit", 2, 1);
    wr(0, 32'h800);
    wr(2, 1);
    rchk("R8 global cleared", 2, 0);
    idle(1);
    chk("R7 irq drops", {31'b0, irq}, 0);
  endtask

  task automatic t_enables();
    wr(3, 0);
    pulse_evt(12'h800);
    idle(2);
    rchk("R5 status-enable gates", 2, 0);
    wr(4, 0); wr(3, 1);
    idle(2);
    rchk("R5 set after enable", 2, 1);
    chk("R7 signal-enable gates irq", {31'b0, irq}, 0);
    wr(4, 1);
    idle(1);
    chk("R7 irq after signal-enable", {31'b0, irq}, 1);
    wr(3, 0);
    rchk("R9 latched bit kept", 2, 1);
    wr(0, 32'h800); wr(2, 1);
    rchk("R8 card bit clear", 2, 0);
  endtask

  task automatic t_sibling();
    wr(3, 2); wr(4, 2);
    pulse_sib();
    rchk("R6 sibling latched", 2, 2);
    idle(1);
    chk("R7 irq from sibling", {31'b0, irq}, 1);
    wr(3, 0);
    rchk("R9 sibling kept", 2, 2);
    wr(2, 2);
    rchk("R8 sibling cleared", 2, 0);
    pulse_sib();
    rchk("R6 sibling gated", 2, 0);
  endtask

  task automatic t_unmapped();
    wr(1, 32'h00F); wr(3, 2); wr(4, 1);
    wr(5, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    rchk("R8 unmapped len", 1, 32'h00F);
    rchk("R8 unmapped gsen", 3, 2);
    rchk("R8 unmapped gsig", 4, 1);
    rchk("R8 unmapped reads zero", 5, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(2);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_enable_layout();
    t_event_disabled();
    t_unimpl();
    t_w1c();
    t_set_wins();
    t_global_card();
    t_enables();
    t_sibling();
    t_unmapped();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule